// File: doc/BRIEF.md
# Dual-Clock FIFO with Latched-Role Enable

This block is a 9-bit first-in first-out buffer. A write clock and a read clock run freely and independently. Both sides are plain level enables, active low. On the write side, `full_n` serves as the ready signal. A word is taken on a write-clock edge only when the write enables qualify and `full_n` is high. With `full_n` low, the producer has to hold the word and retry, because a blocked attempt is discarded and not queued. On the read side, `empty_n` serves as the valid signal. A word moves into the output register `q` on a read-clock edge only when the read enables qualify and `empty_n` is high.

The input `wr_en2_ld` has two possible roles, and its level during reset picks one of them. If it is held high during reset, it becomes a second write enable and has no effect on reads. If it is held low during reset, it becomes a load strobe. While the strobe is low, the port is reserved for offset access, so the FIFO neither accepts writes nor performs reads. While the strobe is high, the single write enable `wr_en1_n` is enough to write.

The pointers are one bit wider than the address. They cross between clock domains in Gray code through two-flop synchronizers. `full_n` is updated only by the write clock and `empty_n` only by the read clock. The active-low `oe_n` input drives `q_valid`, which stands in for the three-state condition of the output.

Top module: `dcfifo_top`

## Requirements
- R1: While `rst_n` is low and just after it is released, `empty_n` is 0, `full_n` is 1 and `q` is 0.
- R2: If `wr_en2_ld` is 1 while reset is low (two-enable mode), a write needs `wr_en1_n`=0 and `wr_en2_ld`=1 at a write-clock edge. With `wr_en2_ld`=0 nothing is stored, and reads do not depend on `wr_en2_ld`.
- R3: If `wr_en2_ld` is 0 while reset is low (load mode), then while `wr_en2_ld` is 0 no word is written, no word is read and `q` holds. While `wr_en2_ld` is 1, `wr_en1_n`=0 alone writes.
- R4: A read happens on a read-clock edge only when `rd_en1_n`=0, `rd_en2_n`=0 and `empty_n`=1. Words come out in the order they were written.
- R5: `full_n` drops on the write-clock edge that stores the DEPTH-th unread word. While it is 0, write attempts are ignored and no word is overwritten.
- R6: `empty_n` drops on the read-clock edge that takes the last unread word. While it is 0, read attempts are ignored and `q` keeps the last word read.
- R7: A word written into an empty FIFO does not raise `empty_n` at the first read-clock edge after the write. It can be read only after `empty_n` has risen.
- R8: `q_valid` equals the inverse of `oe_n`. `oe_n` does not change the contents of `q`.
- R9: After reads free space in a full FIFO, `full_n` returns to 1 within a few write-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset for both domains; latches the role of `wr_en2_ld` |
| din | input | 9 | Write data |
| wr_en1_n | input | 1 | Primary write enable, active low |
| wr_en2_ld | input | 1 | Second write enable (active high) or load strobe (active low) |
| full_n | output | 1 | Full flag, active low, write-clock domain |
| rd_en1_n | input | 1 | Read enable, active low |
| rd_en2_n | input | 1 | Read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| q | output | 9 | Output register |
| q_valid | output | 1 | Output qualifier standing in for a driven bus |
| empty_n | output | 1 | Empty flag, active low, read-clock domain |

## Verification
The bench builds the FIFO with DEPTH=64 and uses write and read clocks of unrelated periods. With that depth, a complete fill to the full boundary and a complete drain fit easily into the run. The fill follows a single word, so both pointers wrap past the top of the address space and the wrap bit of the Gray comparison is exercised. Both reset-selected roles of `wr_en2_ld` are brought up in turn. In each role, writes and reads are tried with the blocking enable levels and checked against an arithmetic model queue.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  localparam int DATA_W = 9;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/dcfifo_sync2.sv
module dcfifo_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dcfifo_ram.sv
module dcfifo_ram
  import dcfifo_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  logic [AW-1:0] raddr,
  output word_t         rdata
);
  localparam int WORDS = 1 << AW;
  word_t cells [WORDS];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dcfifo_wr_ctl.sv
module dcfifo_wr_ctl #(
  parameter int AW = 6
) (
  input  logic        wclk,
  input  logic        rst_n,
  input  logic        push_req,
  input  logic [AW:0] rgray_s,
  output logic [AW:0] wgray,
  output logic [AW-1:0] waddr,
  output logic        push,
  output logic        full_n
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wbin, wbin_nxt, wgray_nxt, far_side;

  function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  assign push      = push_req && full_n;
  assign wbin_nxt  = wbin + {{(PW-1){1'b0}}, push};
  assign wgray_nxt = wbin_nxt ^ (wbin_nxt >> 1);
  assign far_side  = {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]};
  assign waddr     = wbin[AW-1:0];

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      full_n <= 1'b1;
    end else begin
      wbin   <= wbin_nxt;
      wgray  <= wgray_nxt;
      full_n <= (wgray_nxt != far_side);
    end
  end

  // R5: unread words never exceed the array size
  assert_occupancy_R5: assert property (@(posedge wclk) disable iff (!rst_n)
    (wbin - gray_to_bin(rgray_s)) <= PW'(DEPTH));

  // R5: a low full flag freezes the write pointer
  assert_no_overflow_R5: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |=> $stable(wgray));

  // R4: the crossing pointer moves by at most one bit per edge
  assert_gray_step_R4: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/dcfifo_rd_ctl.sv
module dcfifo_rd_ctl
  import dcfifo_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          pop_req,
  input  logic [AW:0]   wgray_s,
  input  word_t         rdata,
  output logic [AW:0]   rgray,
  output logic [AW-1:0] raddr,
  output logic          empty_n,
  output word_t         q
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rbin, rbin_nxt, rgray_nxt;
  logic          pop;

  assign pop       = pop_req && empty_n;
  assign rbin_nxt  = rbin + {{(PW-1){1'b0}}, pop};
  assign rgray_nxt = rbin_nxt ^ (rbin_nxt >> 1);
  assign raddr     = rbin[AW-1:0];

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      empty_n <= 1'b0;
      q       <= '0;
    end else begin
      rbin    <= rbin_nxt;
      rgray   <= rgray_nxt;
      empty_n <= (rgray_nxt != wgray_s);
      if (pop) q <= rdata;
    end
  end

  // R6: an empty FIFO keeps the last word read
  assert_no_underflow_R6: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |=> $stable(q));

  // R4: a high empty flag means the synchronized write pointer is ahead
  assert_flag_consistent_R4: assert property (@(posedge rclk) disable iff (!rst_n)
    empty_n |-> (rgray != wgray_s));
endmodule

// File: rtl/dcfifo_top.sv
module dcfifo_top
  import dcfifo_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic       wclk,
  input  logic       rclk,
  input  logic       rst_n,
  input  logic [8:0] din,
  input  logic       wr_en1_n,
  input  logic       wr_en2_ld,
  output logic       full_n,
  input  logic       rd_en1_n,
  input  logic       rd_en2_n,
  input  logic       oe_n,
  output logic [8:0] q,
  output logic       q_valid,
  output logic       empty_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          two_en;
  logic          push, push_req, pop_req;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] waddr, raddr;
  word_t         rdata, q_reg;

  // role of wr_en2_ld captured while reset is held
  always_ff @(posedge wclk) begin
    if (!rst_n) two_en <= wr_en2_ld;
  end

  assign push_req = !wr_en1_n && wr_en2_ld;
  assign pop_req  = !rd_en1_n && !rd_en2_n && (two_en || wr_en2_ld);

  dcfifo_wr_ctl #(.AW(AW)) i_wr (
    .wclk(wclk), .rst_n(rst_n), .push_req(push_req), .rgray_s(rgray_s),
    .wgray(wgray), .waddr(waddr), .push(push), .full_n(full_n)
  );

  dcfifo_ram #(.AW(AW)) i_ram (
    .wclk(wclk), .we(push), .waddr(waddr), .wdata(din),
    .raddr(raddr), .rdata(rdata)
  );

  dcfifo_sync2 #(.W(PW)) i_w2r (
    .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
  );

  dcfifo_sync2 #(.W(PW)) i_r2w (
    .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
  );

  dcfifo_rd_ctl #(.AW(AW)) i_rd (
    .rclk(rclk), .rst_n(rst_n), .pop_req(pop_req), .wgray_s(wgray_s),
    .rdata(rdata), .rgray(rgray), .raddr(raddr), .empty_n(empty_n), .q(q_reg)
  );

  assign q       = q_reg;
  assign q_valid = !oe_n;

  // R3: in load mode a low strobe leaves the output register untouched
  assert_load_hold_R3: assert property (@(posedge rclk) disable iff (!rst_n)
    (!two_en && !wr_en2_ld) |=> $stable(q));
endmodule

// File: tb/test_dcfifo_top.sv
module test_dcfifo_top;
  import dcfifo_pkg::*;

  localparam int DEPTH    = 64;
  localparam int WCLK_PER = 10;
  localparam int RCLK_PER = 14;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic [8:0] din = '0;
  logic wr_en1_n = 1'b1, wr_en2_ld = 1'b1, rd_en1_n = 1'b1, rd_en2_n = 1'b1, oe_n = 1'b0;
  logic full_n, empty_n, q_valid;
  logic [8:0] q;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  bit mode_two = 1'b1;
  word_t model[$];
  word_t last_q = '0;

  always #(WCLK_PER/2) wclk = ~wclk;
  always #(RCLK_PER/2) rclk = ~rclk;

  dcfifo_top #(.DEPTH(DEPTH)) i_dcfifo_top (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .din(din), .wr_en1_n(wr_en1_n),
    .wr_en2_ld(wr_en2_ld), .full_n(full_n), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
    .oe_n(oe_n), .q(q), .q_valid(q_valid), .empty_n(empty_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic do_reset(input logic role);
    rst_n = 1'b0;
    wr_en2_ld = role;
    mode_two = role;
    model.delete();
    last_q = '0;
    repeat (4) @(posedge wclk);
    repeat (4) @(posedge rclk);
    chk(empty_n == 1'b0 && full_n == 1'b1 && q == 9'd0, "R1 in reset",
        {empty_n, full_n, q}, {2'b01, 9'd0});
    @(negedge wclk);
    rst_n = 1'b1;
    @(negedge rclk);
    chk(empty_n == 1'b0 && full_n == 1'b1 && q == 9'd0, "R1 after release",
        {empty_n, full_n, q}, {2'b01, 9'd0});
  endtask

  task automatic wr(input word_t d, input logic w1n, input logic w2);
    bit acc;
    @(negedge wclk);
    din = d; wr_en1_n = w1n; wr_en2_ld = w2;
    acc = full_n && !w1n && w2;
    @(posedge wclk);
    #1 wr_en1_n = 1'b1;
    if (acc) model.push_back(d);
  endtask

  task automatic rd(input logic r1n, input logic r2n, input logic ld, input string req);
    bit acc;
    word_t exp;
    @(negedge rclk);
    rd_en1_n = r1n; rd_en2_n = r2n; wr_en2_ld = ld;
    acc = empty_n && !r1n && !r2n && (mode_two || ld);
    exp = last_q;
    if (acc) begin
      if (model.size() == 0) chk(1'b0, req, 1, 0);
      else exp = model.pop_front();
    end
    @(negedge rclk);
    rd_en1_n = 1'b1; rd_en2_n = 1'b1;
    chk(q == exp, req, q, exp);
    last_q = exp;
  endtask

  task automatic wait_ne();
    for (int i = 0; i < 40 && !empty_n; i++) @(negedge rclk);
  endtask

  initial begin
    #(WCLK_PER * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // two-enable mode
    do_reset(1'b1);

    // R2: second enable low blocks the write
    for (int i = 0; i < 3; i++) wr(word_t'(9'h0F0 + i), 1'b0, 1'b0);
    repeat (8) @(negedge rclk);
    chk(empty_n == 1'b0, "R2 write blocked by wr_en2_ld low", empty_n, 0);

    // R7: first word latency
    wr(9'h1A5, 1'b0, 1'b1);
    @(negedge rclk);
    chk(empty_n == 1'b0, "R7 empty_n not raised at first read edge", empty_n, 0);
    wait_ne();
    chk(empty_n == 1'b1, "R7 empty_n rises", empty_n, 1);

    // R4: single read enable is not enough
    rd(1'b0, 1'b1, 1'b1, "R4 only rd_en1_n low");
    rd(1'b1, 1'b0, 1'b1, "R4 only rd_en2_n low");
    // R2: in two-enable mode reads ignore wr_en2_ld
    rd(1'b0, 1'b0, 1'b0, "R2 read with wr_en2_ld low");
    chk(empty_n == 1'b0, "R6 empty after last read", empty_n, 0);

    // R6: reads on empty hold q
    for (int i = 0; i < 3; i++) rd(1'b0, 1'b0, 1'b1, "R6 read on empty holds q");

    // R5: fill to the boundary, pointers wrap past the top
    for (int i = 0; i < DEPTH; i++) begin
      wr(word_t'((i * 37 + 5) & 9'h1FF), 1'b0, 1'b1);
      @(negedge wclk);
      chk(full_n == (i + 1 < DEPTH), "R5 full_n during fill", full_n, int'(i + 1 < DEPTH));
    end
    for (int i = 0; i < 5; i++) wr(word_t'(9'h155), 1'b0, 1'b1);
    @(negedge wclk);
    chk(full_n == 1'b0, "R5 full_n held by ignored writes", full_n, 0);

    // R4/R5: drain, order kept, no extra word
    wait_ne();
    for (int i = 0; i < DEPTH; i++) rd(1'b0, 1'b0, 1'b1, "R4 drain order");
    chk(empty_n == 1'b0, "R6 empty_n low after last word", empty_n, 0);
    chk(model.size() == 0, "R5 nothing overwritten", model.size(), 0);
    repeat (6) @(negedge wclk);
    chk(full_n == 1'b1, "R9 full_n returns", full_n, 1);

    // R8: output enable
    @(negedge rclk);
    oe_n = 1'b1;
    #1 chk(q_valid == 1'b0 && q == last_q, "R8 oe_n high", {q_valid, q}, {1'b0, last_q});
    oe_n = 1'b0;
    #1 chk(q_valid == 1'b1 && q == last_q, "R8 oe_n low", {q_valid, q}, {1'b1, last_q});

    // load mode
    do_reset(1'b0);
    for (int i = 0; i < 3; i++) wr(word_t'(9'h033 + i), 1'b0, 1'b0);
    repeat (8) @(negedge rclk);
    chk(empty_n == 1'b0, "R3 strobe low blocks writes", empty_n, 0);
    for (int i = 0; i < 4; i++) wr(word_t'(9'h100 + i * 9), 1'b0, 1'b1);
    wait_ne();
    chk(empty_n == 1'b1, "R3 single enable writes", empty_n, 1);
    for (int i = 0; i < 3; i++) rd(1'b0, 1'b0, 1'b0, "R3 strobe low blocks reads");
    chk(empty_n == 1'b1, "R3 data kept while strobe low", empty_n, 1);
    for (int i = 0; i < 4; i++) rd(1'b0, 1'b0, 1'b1, "R3 reads with strobe high");
    chk(empty_n == 1'b0, "R6 empty after load-mode drain", empty_n, 0);

    finish_run();
  end
endmodule